// File: doc/BRIEF.md
# Sliding-Scale Offset Corrector

This block drives the dither offset of a sliding-scale linearity correction scheme for a peak-sensing analogue-to-digital converter. For every conversion it supplies a small offset code to the external summing DAC. The offset is subtracted from the analogue input, so a full-scale pulse never overranges the converter. When the conversion finishes, the block adds the same offset back to the raw converter code. Over many conversions each input level is spread across many converter bins, and the differences in bin width average out.

The generator moves to its next code on each conversion-start strobe. It either counts upward or steps through a maximal LFSR extended with the all-zero state, and a parameter picks which. In both cases every code in the offset range appears exactly once per period. The code in use when a conversion starts is captured at that moment, and the correction uses the captured code, even though the generator has moved on by the time the raw result arrives. Two flags mark results that cannot be trusted. One marks a zero raw code while a nonzero offset was applied, which means the input was driven below zero. The other marks a sum above full scale; that result is clamped. A bypass input forces the offset to zero for calibration runs.

Top module: `slidingScaleCorrector`

## Requirements
- R1: After reset, dacCode is 0, resultValid is 0, result is 0, and both underRange and overRange are 0.
- R2: With USE_LFSR=0, dacCode goes up by one (modulo 64) in the cycle after each convStart taken while bypass is low. dacCode does not change in any cycle without convStart.
- R3: With USE_LFSR=1, any 64 consecutive convStart strobes (bypass low) show each of the 64 codes 0x00..0x3F exactly once on dacCode, and the 65th code equals the first.
- R4: The offset applied to a result is the dacCode value present in the cycle of the most recent convStart. Later generator advances do not alter it.
- R5: resultValid is high exactly in the cycle after rawValid. In that cycle result equals rawCode plus the latched offset, taken as unsigned 13-bit values.
- R6: When rawCode plus the latched offset exceeds 8191, result is 8191 and overRange is 1. Otherwise overRange is 0.
- R7: underRange is 1 exactly when the raw code was 0 and the latched offset was nonzero.
- R8: While bypass is high, dacCode reads 0, a convStart latches an offset of 0, and the generator holds its state. When bypass falls, the sequence resumes where it stopped.
- R9: If convStart and rawValid occur in the same cycle, the result uses the offset latched before that cycle, and the new offset applies to the following result.
- R10: result, underRange and overRange hold their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Conversion start strobe; latches the offset and advances the generator |
| rawValid | input | 1 | Raw converter code is present on rawCode this cycle |
| rawCode | input | 13 | Raw converter code |
| bypass | input | 1 | Forces the offset to zero and freezes the generator |
| dacCode | output | 6 | Offset code for the summing DAC |
| result | output | 13 | Corrected code |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| underRange | output | 1 | Input was driven below zero by the offset |
| overRange | output | 1 | Corrected sum exceeded full scale and was clamped |

## Verification
The counting variant is driven with long runs of conversions at mid-scale codes. The runs pass the 63-to-0 wrap, which separates a correct modulo step from an off-by-one or a stuck generator. Raw codes near full scale paired with large offsets separate correct clamping from silent wraparound. Zero raw codes with zero and with nonzero offsets separate the underrange rule from a plain zero test. Overlapping start and result strobes, plus runs with bypass toggled, show which offset was captured. A second instance in LFSR mode is stepped through a full period to confirm that all 64 codes appear and that the sequence repeats.

// File: rtl/ssPkg.sv
package ssPkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic latchOffset;
    logic computeResult;
  } ssStrobe_t;

  // Feedback taps for maximal LFSRs of small widths (bit i = stage i)
  function automatic logic [7:0] lfsrTaps(input int width);
    case (width)
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      default: return 8'b1011_1000;
    endcase
  endfunction
endpackage

// File: rtl/ssCtrl.sv
module ssCtrl
  import ssPkg::*;
#(
  parameter int OFS_W    = 6,
  parameter bit USE_LFSR = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             rawValid,
  input  logic             bypass,
  output logic [OFS_W-1:0] dacCode,
  output ssStrobe_t        strobe
);
  localparam logic [7:0] TAPS8 = lfsrTaps(OFS_W);
  localparam logic [OFS_W-1:0] TAPS = TAPS8[OFS_W-1:0];

  logic [OFS_W-1:0] genState;
  logic [OFS_W-1:0] nextState;

  generate
    if (USE_LFSR) begin : g_lfsr
      logic feedback;
      // Extra term on all-zero low bits splices the zero state into the cycle
      always_comb begin
        feedback  = (^(genState & TAPS)) ^ (genState[OFS_W-2:0] == '0);
        nextState = {genState[OFS_W-2:0], feedback};
      end
    end else begin : g_count
      always_comb nextState = genState + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) genState <= '0;
    else if (convStart && !bypass) genState <= nextState;
  end

  always_comb begin
    dacCode              = bypass ? '0 : genState;
    strobe.latchOffset   = convStart;
    strobe.computeResult = rawValid;
  end
endmodule

// File: rtl/ssDatapath.sv
module ssDatapath
  import ssPkg::*;
#(
  parameter int RAW_W = 13,
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssStrobe_t        strobe,
  input  logic [OFS_W-1:0] dacCode,
  input  logic [RAW_W-1:0] rawCode,
  output logic [RAW_W-1:0] result,
  output logic             resultValid,
  output logic             underRange,
  output logic             overRange
);
  localparam int SUM_W = RAW_W + 1;
  localparam logic [RAW_W-1:0] FULL_SCALE = '1;

  logic [OFS_W-1:0] heldOffset;
  logic [SUM_W-1:0] sum;

  always_comb sum = {1'b0, rawCode} + SUM_W'(heldOffset);

  // Offset in force for the conversion now under way
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldOffset <= '0;
    else if (strobe.latchOffset) heldOffset <= dacCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      underRange  <= 1'b0;
      overRange   <= 1'b0;
    end else begin
      resultValid <= strobe.computeResult;
      if (strobe.computeResult) begin
        overRange  <= sum[SUM_W-1];
        underRange <= (rawCode == '0) && (heldOffset != '0);
        result     <= sum[SUM_W-1] ? FULL_SCALE : sum[RAW_W-1:0];
      end
    end
  end
endmodule

// File: rtl/slidingScaleCorrector.sv
module slidingScaleCorrector
  import ssPkg::*;
#(
  parameter int RAW_W    = 13,
  parameter int OFS_W    = 6,
  parameter bit USE_LFSR = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             rawValid,
  input  logic [RAW_W-1:0] rawCode,
  input  logic             bypass,
  output logic [OFS_W-1:0] dacCode,
  output logic [RAW_W-1:0] result,
  output logic             resultValid,
  output logic             underRange,
  output logic             overRange
);
  ssStrobe_t strobe;

  ssCtrl #(.OFS_W(OFS_W), .USE_LFSR(USE_LFSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .rawValid(rawValid),
    .bypass(bypass), .dacCode(dacCode), .strobe(strobe)
  );

  ssDatapath #(.RAW_W(RAW_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dacCode(dacCode),
    .rawCode(rawCode), .result(result), .resultValid(resultValid),
    .underRange(underRange), .overRange(overRange)
  );
endmodule

// File: rtl/ssChecker.sv
module ssChecker #(
  parameter int RAW_W    = 13,
  parameter int OFS_W    = 6,
  parameter bit USE_LFSR = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             convStart,
  input logic             rawValid,
  input logic             bypass,
  input logic [OFS_W-1:0] dacCode,
  input logic [RAW_W-1:0] result,
  input logic             resultValid,
  input logic             underRange,
  input logic             overRange
);
  localparam logic [RAW_W-1:0] FULL_SCALE = '1;

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |=> resultValid);
  p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |=> !resultValid);
  p_dac_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    !convStart |=> ($stable(bypass) -> $stable(dacCode)));
  p_bypass_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    bypass |-> dacCode == '0);
  p_clamp_r6: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> result == FULL_SCALE);
  p_under_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    underRange |-> (result != '0 && !overRange));
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |=> ($stable(result) && $stable(underRange) && $stable(overRange)));

  generate
    if (!USE_LFSR) begin : g_cnt
      p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
        (convStart && !bypass) |=> (!bypass -> dacCode == $past(dacCode) + 1'b1));
    end
  endgenerate
endmodule

bind slidingScaleCorrector ssChecker #(.RAW_W(RAW_W), .OFS_W(OFS_W), .USE_LFSR(USE_LFSR)) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .rawValid(rawValid),
  .bypass(bypass), .dacCode(dacCode), .result(result),
  .resultValid(resultValid), .underRange(underRange), .overRange(overRange)
);

// File: tb/slidingScaleCorrector_bench.sv
`timescale 1ns/1ps
module slidingScaleCorrector_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b0, rawValid = 1'b0, bypass = 1'b0;
  logic [12:0] rawCode = '0;
  logic [5:0]  dacCode;
  logic [12:0] result;
  logic        resultValid, underRange, overRange;

  logic        lCs = 1'b0, lByp = 1'b0, lRv = 1'b0;
  logic [12:0] lRaw = '0;
  logic [5:0]  lDac;
  logic [12:0] lRes;
  logic        lValid, lUnder, lOver;

  int vectors = 0, fails = 0;
  int genM = 0, heldM = 0, resM = 0;
  bit validM = 0, underM = 0, overM = 0;

  always #2.5 clk = ~clk;

  slidingScaleCorrector u_slidingScaleCorrector (
    .clk(clk), .rstN(rstN), .convStart(convStart), .rawValid(rawValid),
    .rawCode(rawCode), .bypass(bypass), .dacCode(dacCode), .result(result),
    .resultValid(resultValid), .underRange(underRange), .overRange(overRange)
  );

  slidingScaleCorrector #(.USE_LFSR(1'b1)) u_lfsr (
    .clk(clk), .rstN(rstN), .convStart(lCs), .rawValid(lRv),
    .rawCode(lRaw), .bypass(lByp), .dacCode(lDac), .result(lRes),
    .resultValid(lValid), .underRange(lUnder), .overRange(lOver)
  );

  task automatic compare(input string tag);
    int expDac;
    expDac = bypass ? 0 : genM;
    vectors++;
    if (dacCode !== 6'(expDac) || resultValid !== validM || result !== 13'(resM) ||
        underRange !== underM || overRange !== overM) begin
      fails++;
      $display("FAIL %s: dac=%0d valid=%0b res=%0d under=%0b over=%0b expected dac=%0d valid=%0b res=%0d under=%0b over=%0b",
               tag, dacCode, resultValid, result, underRange, overRange,
               expDac, validM, resM, underM, overM);
    end
  endtask

  // Apply one cycle of stimulus, update the model, compare after the edge
  task automatic step(input bit cs, input bit rv, input int raw, input bit byp, input string tag);
    int sum;
    convStart = cs; rawValid = rv; rawCode = 13'(raw); bypass = byp;
    validM = rv;
    if (rv) begin
      sum    = raw + heldM;
      overM  = sum > 8191;
      underM = (raw == 0) && (heldM != 0);
      resM   = overM ? 8191 : sum;
    end
    if (cs) begin
      heldM = byp ? 0 : genM;
      if (!byp) genM = (genM + 1) % 64;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit seen [64];
    int first, code;
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // Idle: generator must not move (R2)
    repeat (3) step(0, 0, 0, 0, "R2");
    // Zero offset latched, zero raw: no underrange (R7)
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, "R10");
    // Offset 1 latched, raw 0: underrange (R7)
    step(1, 0, 0, 0, "R4");
    step(0, 1, 0, 0, "R7");
    // Long run of conversions crossing the 63->0 wrap (R2, R4, R5)
    for (int i = 0; i < 70; i++) begin
      step(1, 0, 0, 0, "R2");
      step(0, 0, 0, 0, "R4");
      step(0, 1, 1000 + 37 * i, 0, "R5");
    end
    // Near full scale with large offset: clamp (R6)
    while (genM != 60) step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R4");
    step(0, 1, 8191, 0, "R6");
    step(0, 1, 8131, 0, "R6");
    step(0, 1, 8132, 0, "R6");
    step(0, 1, 8150, 0, "R6");
    step(0, 0, 0, 0, "R10");
    // Overlapping start and result (R9)
    step(1, 1, 500, 0, "R9");
    step(1, 1, 500, 0, "R9");
    step(0, 1, 500, 0, "R9");
    // Bypass: code zero, generator frozen, zero offset latched (R8)
    step(0, 0, 0, 1, "R8");
    step(1, 0, 0, 1, "R8");
    step(1, 0, 0, 1, "R8");
    step(0, 1, 0, 1, "R8");
    step(0, 1, 8191, 1, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    step(0, 1, 0, 0, "R7");

    // LFSR variant: full period visits every code once (R3)
    first = lDac;
    for (int i = 0; i < 64; i++) begin
      code = lDac;
      vectors++;
      if (seen[code]) begin
        fails++;
        $display("FAIL R3: code %0d repeated at step %0d, expected a new code", code, i);
      end
      seen[code] = 1'b1;
      lCs = 1'b1;
      @(posedge clk);
      @(negedge clk);
      lCs = 1'b0;
    end
    vectors++;
    if (lDac !== 6'(first)) begin
      fails++;
      $display("FAIL R3: after period code=%0d expected=%0d", lDac, first);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule